// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a bus-attached watchdog for a single clock domain. A 32-bit down-counter advances on a core tick strobe once software has loaded a timeout and set the enable bit. When the counter runs out the first time, the block raises an interrupt and starts a fresh timeout. If the counter runs out again before software has cleared that interrupt, the block raises a system reset request, as long as reset generation is enabled.

Software services the watchdog by writing the interrupt-clear register. That write both drops the pending interrupt and restarts the count from the load value. Every configuration register sits behind a write lock. The lock opens only when one specific 32-bit key is written to the lock register, and any other value written there closes it again. Bus access uses APB-style signalling: a setup phase, then an access phase, with no wait states.

Top module: `wdog_guard`

## Requirements
- R1: After block reset the lock register reads 1, control reads 0, the load and counter registers both read 0xFFFFFFFF, and irq_o and sysrst_req_o are low.
- R2: The lock register is at offset 0xC00 and reads bit 0 = 1 when locked. Writing 0x1ACCE551 there unlocks (it then reads 0). Writing any other value locks again.
- R3: While locked, writes to load (0x000), control (0x008) and interrupt-clear (0x00C) change nothing.
- R4: An accepted write to the load register sets both the load register (read at 0x000) and the counter (read at 0x004) to the written value in the next cycle.
- R5: With control bit 0 set, the counter drops by one on each cycle in which tick is high, and holds when tick is low. With bit 0 clear it stays frozen whatever tick does.
- R6: A tick while the enabled counter reads zero is an expiry. The counter reloads from the load register and the raw interrupt is set, so one timeout lasts load+1 ticks.
- R7: The status register at 0x014 bit 0 and irq_o both equal the raw interrupt ANDed with control bit 0. Control bits 31:2 read as zero.
- R8: An accepted write to the interrupt-clear register clears the raw interrupt and reloads the counter from the load register.
- R9: An expiry while the raw interrupt is already set and control bit 1 is set drives sysrst_req_o high. It stays high until block reset. With bit 1 clear, no request is made and the interrupt stays set.
- R10: An accepted write to load or interrupt-clear takes priority over a tick in the same cycle. That tick neither decrements nor causes an expiry.
- R11: Read data is captured in the setup phase and is valid throughout the access phase. Offset 0x00C and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for bus and counter |
| rst | input | 1 | Synchronous active-high block reset |
| tick | input | 1 | Core tick strobe; the counter advances on cycles where it is high |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| irq_o | output | 1 | Masked interrupt output |
| sysrst_req_o | output | 1 | Sticky system reset request |

## Verification
The bench targets the cycles where several things meet. These are a load write or service write that lands on a tick, a service write that lands exactly on the expiry tick, and a second expiry with reset generation on and then off. A design that lets the tick win would show a counter one below the written value, or a stray interrupt. One that escalates on the first expiry, or ignores the reset-enable bit, would assert the reset request early or wrongly. The bench also tries writes under the lock and mask toggling of a pending interrupt. A leaky lock would show changed register contents, and wrong masking would show irq_o disagreeing with the status register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Register offsets (byte addresses)
  localparam int unsigned OFS_LOAD   = 'h000;
  localparam int unsigned OFS_COUNT  = 'h004;
  localparam int unsigned OFS_CTRL   = 'h008;
  localparam int unsigned OFS_CLEAR  = 'h00C;
  localparam int unsigned OFS_STATUS = 'h014;
  localparam int unsigned OFS_LOCK   = 'hC00;
  // Key that opens the write lock
  localparam logic [31:0] OPEN_KEY   = 32'h1ACC_E551;
endpackage

// File: rtl/wdog_bus.sv
module wdog_bus
  import wdog_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned DW  = 32,
  parameter logic [DW-1:0] KEY = DW'(OPEN_KEY)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  input  logic [DW-1:0] load_q,
  input  logic [DW-1:0] cnt_q,
  input  logic          en_q,
  input  logic          rsten_q,
  input  logic          irq_q,
  output logic          wr_load,
  output logic          wr_ctrl,
  output logic          wr_clr,
  output logic [DW-1:0] prdata
);
  logic          locked_q;
  logic          acc_wr, setup_rd, wr_lock;
  logic [DW-1:0] rd_val;

  assign acc_wr   = psel & penable & pwrite;
  assign setup_rd = psel & ~penable & ~pwrite;
  assign wr_lock  = acc_wr & (paddr == AW'(OFS_LOCK));
  assign wr_load  = acc_wr & ~locked_q & (paddr == AW'(OFS_LOAD));
  assign wr_ctrl  = acc_wr & ~locked_q & (paddr == AW'(OFS_CTRL));
  assign wr_clr   = acc_wr & ~locked_q & (paddr == AW'(OFS_CLEAR));

  always_ff @(posedge clk) begin
    if (rst)          locked_q <= 1'b1;
    else if (wr_lock) locked_q <= (pwdata != KEY);
  end

  always_comb begin
    rd_val = '0;
    if (paddr == AW'(OFS_LOAD))        rd_val = load_q;
    else if (paddr == AW'(OFS_COUNT))  rd_val = cnt_q;
    else if (paddr == AW'(OFS_CTRL))   rd_val = {{(DW-2){1'b0}}, rsten_q, en_q};
    else if (paddr == AW'(OFS_STATUS)) rd_val = {{(DW-1){1'b0}}, irq_q};
    else if (paddr == AW'(OFS_LOCK))   rd_val = {{(DW-1){1'b0}}, locked_q};
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (setup_rd) prdata <= rd_val;
  end

  // R2: lock state changes only through a lock-register write
  assert_lock_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_lock |=> $stable(locked_q));
  // R3: locked block accepts no configuration write
  assert_locked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    locked_q |-> !(wr_load || wr_ctrl || wr_clr));
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          load_wr,
  input  logic [DW-1:0] load_val,
  input  logic          reload,
  output logic [DW-1:0] load_q,
  output logic [DW-1:0] cnt_q,
  output logic          expire
);
  logic hold, step;

  assign hold   = load_wr | reload;
  assign step   = run & tick & ~hold;
  assign expire = step & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '1;
      cnt_q  <= '1;
    end else if (load_wr) begin
      load_q <= load_val;
      cnt_q  <= load_val;
    end else if (reload) begin
      cnt_q  <= load_q;
    end else if (step) begin
      cnt_q  <= expire ? load_q : cnt_q - 1'b1;
    end
  end

  // R4: accepted load write lands in both registers
  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> (cnt_q == $past(load_val)) && (load_q == $past(load_val)));
  // R5: one decrement per tick while running
  assert_dec_R5: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !hold && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R5: frozen when not running and not written
  assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !hold) |=> $stable(cnt_q));
  // R6: expiry reloads from the load register
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt_q == $past(load_q));
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_bits,
  input  logic       clr_wr,
  input  logic       expire,
  output logic       en_q,
  output logic       rsten_q,
  output logic       irq_o,
  output logic       sysrst_o
);
  logic raw_q;
  logic en_d, rsten_d, raw_d, sysrst_d;

  always_comb begin
    en_d     = ctrl_wr ? ctrl_bits[0] : en_q;
    rsten_d  = ctrl_wr ? ctrl_bits[1] : rsten_q;
    raw_d    = clr_wr ? 1'b0 : (raw_q | expire);
    sysrst_d = sysrst_o | (expire & raw_q & rsten_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      rsten_q  <= 1'b0;
      raw_q    <= 1'b0;
      irq_o    <= 1'b0;
      sysrst_o <= 1'b0;
    end else begin
      en_q     <= en_d;
      rsten_q  <= rsten_d;
      raw_q    <= raw_d;
      irq_o    <= raw_d & en_d;
      sysrst_o <= sysrst_d;
    end
  end

  // R6: an expiry leaves the interrupt pending
  assert_expire_irq_R6: assert property (@(posedge clk) disable iff (rst)
    expire |=> raw_q);
  // R7: output equals masked raw interrupt
  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (raw_q & en_q));
  // R8: service write drops the interrupt
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> !raw_q);
  // R9: request is sticky
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    sysrst_o |=> sysrst_o);
  // R9: request rises only on a second expiry with reset generation on
  assert_second_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sysrst_o) |-> $past(raw_q) && $past(rsten_q) && $past(expire));
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          irq_o,
  output logic          sysrst_req_o
);
  logic          wr_load, wr_ctrl, wr_clr, expire;
  logic          en_q, rsten_q;
  logic [DW-1:0] load_q, cnt_q;

  wdog_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .load_q(load_q), .cnt_q(cnt_q),
    .en_q(en_q), .rsten_q(rsten_q), .irq_q(irq_o),
    .wr_load(wr_load), .wr_ctrl(wr_ctrl), .wr_clr(wr_clr), .prdata(prdata)
  );

  wdog_count #(.DW(DW)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .run(en_q),
    .load_wr(wr_load), .load_val(pwdata), .reload(wr_clr),
    .load_q(load_q), .cnt_q(cnt_q), .expire(expire)
  );

  wdog_escalate u_esc (
    .clk(clk), .rst(rst), .ctrl_wr(wr_ctrl), .ctrl_bits(pwdata[1:0]),
    .clr_wr(wr_clr), .expire(expire), .en_q(en_q), .rsten_q(rsten_q),
    .irq_o(irq_o), .sysrst_o(sysrst_req_o)
  );
endmodule

// File: tb/wdog_guard_tb.sv
`timescale 1ns/1ps
module wdog_guard_tb;
  localparam logic [31:0] KEY = 32'h1ACC_E551;
  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                          A_CLR = 12'h00C, A_STAT = 12'h014, A_LOCK = 12'hC00;

  logic clk = 0, rst = 1, tick = 0, psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic irq_o, sysrst_req_o;
  int checks = 0, errors = 0, cyc = 0;
  bit go = 0;

  always #4 clk = ~clk;

  wdog_guard u_dut (.clk(clk), .rst(rst), .tick(tick), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_o(irq_o), .sysrst_req_o(sysrst_req_o));

  // Behavioural reference model
  logic [31:0] m_load, m_cnt, m_prdata;
  bit m_locked, m_en, m_rsten, m_raw, m_rst, m_irq;

  function automatic logic [31:0] mread(input logic [11:0] a);
    case (a)
      A_LOAD: return m_load;
      A_CNT:  return m_cnt;
      A_CTRL: return {30'd0, m_rsten, m_en};
      A_STAT: return {31'd0, m_raw & m_en};
      A_LOCK: return {31'd0, m_locked};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_load = '1; m_cnt = '1; m_prdata = '0; m_locked = 1; m_en = 0;
      m_rsten = 0; m_raw = 0; m_rst = 0; m_irq = 0;
    end else begin
      logic [31:0] o_load, o_cnt;
      bit o_locked, o_en, o_rsten, o_raw, hold, acc;
      o_load = m_load; o_cnt = m_cnt; o_locked = m_locked;
      o_en = m_en; o_rsten = m_rsten; o_raw = m_raw; hold = 0;
      if (psel && !penable && !pwrite) m_prdata = mread(paddr);
      acc = psel && penable && pwrite;
      if (acc && paddr == A_LOCK) m_locked = (pwdata != KEY);
      if (acc && !o_locked) begin
        if (paddr == A_LOAD) begin m_load = pwdata; m_cnt = pwdata; hold = 1; end
        if (paddr == A_CTRL) begin m_en = pwdata[0]; m_rsten = pwdata[1]; end
        if (paddr == A_CLR)  begin m_raw = 0; m_cnt = o_load; hold = 1; end
      end
      if (!hold && o_en && tick) begin
        if (o_cnt == 0) begin
          m_cnt = o_load;
          if (o_raw && o_rsten) m_rst = 1;
          m_raw = 1;
        end else m_cnt = o_cnt - 1;
      end
      m_irq = m_raw & m_en;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (go) begin
    check({31'd0, irq_o}, {31'd0, m_irq}, "R7 model irq_o");
    check({31'd0, sysrst_req_o}, {31'd0, m_rst}, "R9 model sysrst_req_o");
    check(prdata, m_prdata, "R11 model prdata");
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit tick_acc = 0);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; tick = 0;
    @(negedge clk); penable = 1; tick = tick_acc;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; tick = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    check(prdata, exp, tag);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; go = 1;
    // R1 reset state
    rd(A_LOCK, 1, "R1 lock after reset");
    rd(A_LOAD, 32'hFFFF_FFFF, "R1 load after reset");
    rd(A_CNT, 32'hFFFF_FFFF, "R1 count after reset");
    rd(A_CTRL, 0, "R1 ctrl after reset");
    check({31'd0, irq_o}, 0, "R1 irq_o after reset");
    check({31'd0, sysrst_req_o}, 0, "R1 sysrst after reset");
    // R3 locked writes ignored
    wr(A_LOAD, 10); rd(A_LOAD, 32'hFFFF_FFFF, "R3 load locked");
    wr(A_CTRL, 3);  rd(A_CTRL, 0, "R3 ctrl locked");
    // R2 unlock
    wr(A_LOCK, KEY); rd(A_LOCK, 0, "R2 unlocked");
    // R4 load
    wr(A_LOAD, 5); rd(A_LOAD, 5, "R4 load reg"); rd(A_CNT, 5, "R4 count reg");
    // R5 counting and freeze
    wr(A_CTRL, 1); pulse(3); rd(A_CNT, 2, "R5 decrement");
    wr(A_CTRL, 0); pulse(4); rd(A_CNT, 2, "R5 frozen");
    wr(A_CTRL, 32'hFFFF_FFFD); rd(A_CTRL, 1, "R7 reserved bits zero");
    // R6 first expiry
    pulse(3); rd(A_CNT, 5, "R6 reload on expiry"); rd(A_STAT, 1, "R6 status set");
    check({31'd0, irq_o}, 1, "R6 irq_o");
    // R7 masking
    wr(A_CTRL, 0); rd(A_STAT, 0, "R7 masked status");
    check({31'd0, irq_o}, 0, "R7 masked irq_o");
    wr(A_CTRL, 1); check({31'd0, irq_o}, 1, "R7 unmasked irq_o");
    // R9 second expiry without reset enable
    pulse(6); check({31'd0, sysrst_req_o}, 0, "R9 no request when disabled");
    rd(A_STAT, 1, "R9 irq stays");
    // R8 clear
    wr(A_CLR, 0); rd(A_STAT, 0, "R8 cleared"); rd(A_CNT, 5, "R8 reload");
    // R10 priority
    wr(A_LOAD, 7, 1); rd(A_CNT, 7, "R10 load beats tick");
    wr(A_LOAD, 0);
    wr(A_CLR, 0, 1); rd(A_STAT, 0, "R10 clear beats expiry"); rd(A_CNT, 0, "R10 count");
    pulse(1); rd(A_STAT, 1, "R6 load zero expires per tick");
    // R9 escalation
    wr(A_CTRL, 3); pulse(1);
    check({31'd0, sysrst_req_o}, 1, "R9 second expiry request");
    wr(A_CLR, 0); wr(A_CTRL, 0);
    check({31'd0, sysrst_req_o}, 1, "R9 sticky");
    // R11 reads
    rd(A_CLR, 0, "R11 clear reads zero"); rd(12'h100, 0, "R11 unmapped zero");
    // R2 relock, R3 clear ignored
    wr(A_CTRL, 1); pulse(1); rd(A_STAT, 1, "R6 pending before lock");
    wr(A_LOCK, 32'h1ACC_E550); rd(A_LOCK, 1, "R2 relock");
    wr(A_CLR, 0); rd(A_STAT, 1, "R3 clear locked");
    wr(A_CTRL, 0); rd(A_CTRL, 1, "R3 ctrl locked again");
    // R1 block reset clears request
    @(negedge clk); rst = 1; go = 0;
    @(negedge clk); rst = 0;
    @(negedge clk);
    check({31'd0, sysrst_req_o}, 0, "R1 request cleared by reset");
    go = 1;
    rd(A_LOCK, 1, "R1 locked after second reset");
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule